// File: doc/BRIEF.md
# Three-Cache Snoop Inquiry Responder

This block answers inquiry cycles that an outside bus agent drives against three small tag stores. The first belongs to an instruction cache that tracks only valid or invalid. The second belongs to a data cache, and the third to a second-level cache; both of these track the four MESI states. The agent drives a line address, an invalidate qualifier and an active-low strobe. All three stores are probed in the same cycle and the result is merged. The block then drives active-low hit and hit-modified outputs and rewrites the state of every hit line.

When any probed copy is modified, the block raises a write-back request that carries the line address and holds it until the request is acknowledged. No new inquiry is accepted while the request is outstanding. A preload port lets the surrounding logic, or a bench, write a tag and state into any one of the stores. The port refuses a data-cache-exclusive line that coexists with a second-level-modified copy of the same line, in either order of writing.

Top module: `snoop_responder`

## Requirements
- R1: After reset every line in all three stores is invalid, `hit_n` and `hitm_n` are high, and `wb_req` and `pl_reject` are low.
- R2: An inquiry is taken only in a cycle where `snoop_n` is low and at least one bus-release input is active (`addr_hold` high, `backoff_n` low or `bus_hold` high). A strobe without a release has no effect on outputs or line states.
- R3: One clock after an inquiry is taken, `hit_n` goes low if the line is valid in the instruction store or is S, E or M in the data or second-level store. `hit_n` then keeps that value until the next inquiry is taken.
- R4: In the same cycle, `hitm_n` goes low, together with `hit_n`, only when the line is M in the data or second-level store. Otherwise `hitm_n` is high.
- R5: On a modified hit, `wb_req` rises in the same cycle as `hitm_n` falls, and `wb_line` holds the inquired line address. Both hold until `wb_ack` is sampled high, and at that edge `wb_req` and `hitm_n` return high. Exactly one request is issued even when both the data and second-level copies are modified.
- R6: While `wb_req` is high, strobes are ignored and preloads are refused.
- R7: When `snoop_inv` is high with the strobe, every hit line becomes invalid in every store.
- R8: When `snoop_inv` is low, every hit line becomes S (valid in the instruction store), so a repeated non-invalidating inquiry still hits but never reports modified.
- R9: A line address splits into an index (its low 4 bits, address bits 8..5) and a tag (the remaining upper bits). A line in a store with the same index but a different tag does not hit.
- R10: Preload encodings: `pl_sel` 0 = instruction, 1 = data, 2 = second-level, 3 = refused. `pl_state` 0 = I, 1 = S, 2 = E, 3 = M; for the instruction store any nonzero value means valid. `pl_reject` goes high, and nothing is written, when `pl_sel` is 3, or when writing data E over a second-level M copy of the same line, or writing second-level M over a data E copy, or in a cycle where an inquiry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hold | input | 1 | Bus release: address hold, active high |
| backoff_n | input | 1 | Bus release: back-off, active low |
| bus_hold | input | 1 | Bus release: bus hold, active high |
| snoop_n | input | 1 | Inquiry strobe, active low |
| snoop_inv | input | 1 | Invalidate qualifier, sampled with the strobe |
| snoop_line | input | ADDR_W-OFS_W | Inquired line address (byte address bits 31..5) |
| hit_n | output | 1 | Registered hit indication, active low |
| hitm_n | output | 1 | Registered hit-modified indication, active low |
| wb_req | output | 1 | Write-back request |
| wb_line | output | ADDR_W-OFS_W | Line address of the write-back |
| wb_ack | input | 1 | Write-back acknowledge |
| pl_valid | input | 1 | Preload strobe |
| pl_sel | input | 2 | Preload target store |
| pl_line | input | ADDR_W-OFS_W | Preload line address |
| pl_state | input | 2 | Preload state |
| pl_reject | output | 1 | Preload refused this cycle |

## Verification
The assertions assume that the only route into the stores is the preload port with its legality screen. They also assume that `wb_ack` is only driven while a request is outstanding, and that a preload and a strobe are never offered in the same cycle. The bench keeps to these assumptions: it drives one operation per cycle from tasks, and it raises the acknowledge only after it has seen the request. The sweep covers every legal mix of instruction validity, data state and second-level state under both qualifier values, and it steps over the single forbidden pair. The release inputs are rotated through that sweep.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  localparam logic [1:0] SEL_INSTR = 2'd0;
  localparam logic [1:0] SEL_DATA  = 2'd1;
  localparam logic [1:0] SEL_L2    = 2'd2;
  localparam logic [1:0] SEL_NONE  = 2'd3;

  localparam int NUM_STORES = 3;

  function automatic logic is_valid(mesi_t st);
    return st != ST_I;
  endfunction

  function automatic logic is_mod(mesi_t st);
    return st == ST_M;
  endfunction

  // State of a hit line once the inquiry completes.
  function automatic mesi_t after_snoop(mesi_t st, logic inv);
    if (st == ST_I || inv) return ST_I;
    return ST_S;
  endfunction

  // Forbidden coexistence: data copy exclusive while second-level copy modified.
  function automatic logic pair_illegal(mesi_t d_st, mesi_t l2_st);
    return (d_st == ST_E) && (l2_st == ST_M);
  endfunction

endpackage

// File: rtl/snp_tag_array.sv
module snp_tag_array
  import snp_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int TAG_W      = 23,
  parameter bit VALID_ONLY = 1'b0,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output mesi_t            lk_st,
  input  logic             upd_en,
  input  mesi_t            upd_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  mesi_t            wr_st
);

  logic [TAG_W-1:0] tag_q [ENTRIES];
  mesi_t            st_view [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  generate
    if (VALID_ONLY) begin : g_vld
      logic [ENTRIES-1:0] vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vld_q <= '0;
        else if (upd_en) vld_q[lk_idx] <= is_valid(upd_st);
        else if (wr_en)  vld_q[wr_idx] <= is_valid(wr_st);
      end
      for (genvar e = 0; e < ENTRIES; e++) begin : g_view
        assign st_view[e] = vld_q[e] ? ST_S : ST_I;
      end
    end else begin : g_mesi
      mesi_t st_q [ENTRIES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int e = 0; e < ENTRIES; e++) st_q[e] <= ST_I;
        end else if (upd_en) begin
          st_q[lk_idx] <= upd_st;
        end else if (wr_en) begin
          st_q[wr_idx] <= wr_st;
        end
      end
      for (genvar e = 0; e < ENTRIES; e++) begin : g_view
        assign st_view[e] = st_q[e];
      end
    end
  endgenerate

  logic tag_hit;
  assign tag_hit = is_valid(st_view[lk_idx]) && (tag_q[lk_idx] == lk_tag);
  assign lk_st   = tag_hit ? st_view[lk_idx] : ST_I;

  // The resolved state of an inquired line lands in the entry on the next edge.
  assert_update_lands_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> st_view[$past(lk_idx)] == $past(upd_st));

endmodule

// File: rtl/snp_resolve.sv
module snp_resolve
  import snp_pkg::*;
(
  input  mesi_t ic_st,
  input  mesi_t dc_st,
  input  mesi_t l2_st,
  input  logic  inv,
  output logic  any_hit,
  output logic  any_mod,
  output mesi_t ic_nx,
  output mesi_t dc_nx,
  output mesi_t l2_nx
);

  always_comb begin
    any_hit = is_valid(ic_st) | is_valid(dc_st) | is_valid(l2_st);
    any_mod = is_mod(dc_st) | is_mod(l2_st);
    ic_nx   = after_snoop(ic_st, inv);
    dc_nx   = after_snoop(dc_st, inv);
    l2_nx   = after_snoop(l2_st, inv);
  end

endmodule

// File: rtl/snp_resp_ctrl.sv
module snp_resp_ctrl #(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              any_hit,
  input  logic              any_mod,
  input  logic [LINE_W-1:0] snoop_line,
  input  logic              wb_ack,
  output logic              hit_n,
  output logic              hitm_n,
  output logic              wb_req,
  output logic [LINE_W-1:0] wb_line
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_n   <= 1'b1;
      hitm_n  <= 1'b1;
      wb_req  <= 1'b0;
      wb_line <= '0;
    end else if (acc) begin
      hit_n   <= ~any_hit;
      hitm_n  <= ~any_mod;
      wb_req  <= any_mod;
      wb_line <= snoop_line;
    end else if (wb_req && wb_ack) begin
      wb_req  <= 1'b0;
      hitm_n  <= 1'b1;
    end
  end

  assert_req_with_hitm_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !hitm_n);

  assert_hitm_implies_hit_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    !hitm_n |-> !hit_n);

  assert_req_holds_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_line)));

  assert_ack_releases_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack) |=> (!wb_req && hitm_n));

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snp_pkg::*;
#(
  parameter int  ADDR_W  = 32,
  parameter int  OFS_W   = 5,
  parameter int  ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int LINE_W  = ADDR_W - OFS_W,
  localparam int TAG_W   = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_hold,
  input  logic              backoff_n,
  input  logic              bus_hold,
  input  logic              snoop_n,
  input  logic              snoop_inv,
  input  logic [LINE_W-1:0] snoop_line,
  output logic              hit_n,
  output logic              hitm_n,
  output logic              wb_req,
  output logic [LINE_W-1:0] wb_line,
  input  logic              wb_ack,
  input  logic              pl_valid,
  input  logic [1:0]        pl_sel,
  input  logic [LINE_W-1:0] pl_line,
  input  logic [1:0]        pl_state,
  output logic              pl_reject
);

  // ---- inquiry acceptance ----
  logic released, busy, acc;
  assign released = addr_hold | ~backoff_n | bus_hold;
  assign busy     = wb_req;
  assign acc      = ~snoop_n & released & ~busy;

  // A single lookup port per store: the inquiry owns it when taken,
  // otherwise the preload address is probed for the legality screen.
  logic [LINE_W-1:0] look_line;
  logic [IDX_W-1:0]  look_idx, pl_idx;
  logic [TAG_W-1:0]  look_tag, pl_tag;
  assign look_line = acc ? snoop_line : pl_line;
  assign look_idx  = look_line[IDX_W-1:0];
  assign look_tag  = look_line[LINE_W-1:IDX_W];
  assign pl_idx    = pl_line[IDX_W-1:0];
  assign pl_tag    = pl_line[LINE_W-1:IDX_W];

  mesi_t hit_st [NUM_STORES];
  mesi_t nx_st  [NUM_STORES];
  logic  upd_en [NUM_STORES];
  logic  wr_en  [NUM_STORES];

  // ---- preload screen ----
  mesi_t pl_mesi;
  logic  sel_bad, pair_bad, pl_go;
  assign pl_mesi  = mesi_t'(pl_state);
  assign sel_bad  = (pl_sel == SEL_NONE);
  assign pair_bad = ((pl_sel == SEL_DATA) && pair_illegal(pl_mesi, hit_st[2])) ||
                    ((pl_sel == SEL_L2)   && pair_illegal(hit_st[1], pl_mesi));
  assign pl_reject = pl_valid & (sel_bad | pair_bad | acc | busy);
  assign pl_go     = pl_valid & ~(sel_bad | pair_bad | acc | busy);

  // ---- the three stores: index 0 valid-only, 1 data, 2 second level ----
  generate
    for (genvar g = 0; g < NUM_STORES; g++) begin : g_store
      assign upd_en[g] = acc && is_valid(hit_st[g]);
      assign wr_en[g]  = pl_go && (pl_sel == 2'(g));
      snp_tag_array #(
        .ENTRIES   (ENTRIES),
        .TAG_W     (TAG_W),
        .VALID_ONLY(g == 0)
      ) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (look_idx),
        .lk_tag (look_tag),
        .lk_st  (hit_st[g]),
        .upd_en (upd_en[g]),
        .upd_st (nx_st[g]),
        .wr_en  (wr_en[g]),
        .wr_idx (pl_idx),
        .wr_tag (pl_tag),
        .wr_st  (pl_mesi)
      );
    end
  endgenerate

  // ---- merge across stores ----
  logic any_hit, any_mod;
  snp_resolve u_res (
    .ic_st  (hit_st[0]),
    .dc_st  (hit_st[1]),
    .l2_st  (hit_st[2]),
    .inv    (snoop_inv),
    .any_hit(any_hit),
    .any_mod(any_mod),
    .ic_nx  (nx_st[0]),
    .dc_nx  (nx_st[1]),
    .l2_nx  (nx_st[2])
  );

  // ---- registered responses and write-back handshake ----
  snp_resp_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .any_hit   (any_hit),
    .any_mod   (any_mod),
    .snoop_line(snoop_line),
    .wb_ack    (wb_ack),
    .hit_n     (hit_n),
    .hitm_n    (hitm_n),
    .wb_req    (wb_req),
    .wb_line   (wb_line)
  );

  assert_strobe_gate_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_n || !released) |=> $stable(hit_n));

  assert_busy_ignores_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> $stable(hit_n));

  assert_no_illegal_pair_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !pair_illegal(hit_st[1], hit_st[2]));

  assert_reject_blocks_write_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    pl_reject |-> !(wr_en[0] || wr_en[1] || wr_en[2]));

endmodule

// File: tb/sim_snoop_responder.sv
module sim_snoop_responder;

  localparam int LW = 27;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          addr_hold, backoff_n, bus_hold;
  logic          snoop_n, snoop_inv;
  logic [LW-1:0] snoop_line;
  logic          hit_n, hitm_n, wb_req;
  logic [LW-1:0] wb_line;
  logic          wb_ack;
  logic          pl_valid;
  logic [1:0]    pl_sel, pl_state;
  logic [LW-1:0] pl_line;
  logic          pl_reject;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  snoop_responder u0 (
    .clk(clk), .rst_n(rst_n), .addr_hold(addr_hold), .backoff_n(backoff_n),
    .bus_hold(bus_hold), .snoop_n(snoop_n), .snoop_inv(snoop_inv),
    .snoop_line(snoop_line), .hit_n(hit_n), .hitm_n(hitm_n), .wb_req(wb_req),
    .wb_line(wb_line), .wb_ack(wb_ack), .pl_valid(pl_valid), .pl_sel(pl_sel),
    .pl_line(pl_line), .pl_state(pl_state), .pl_reject(pl_reject)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic preload(input logic [1:0] sel, input logic [LW-1:0] ln,
                         input logic [1:0] st, input logic exp_rej, input string req);
    pl_valid = 1'b1; pl_sel = sel; pl_line = ln; pl_state = st;
    #1 check(req, {31'b0, pl_reject}, {31'b0, exp_rej});
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  // rel: 0 none, 1 address hold, 2 back-off, 3 bus hold
  task automatic snoop(input logic [LW-1:0] ln, input logic inv, input int rel);
    snoop_n = 1'b0; snoop_inv = inv; snoop_line = ln;
    addr_hold = (rel == 1); backoff_n = (rel != 2); bus_hold = (rel == 3);
    @(negedge clk);
    snoop_n = 1'b1; snoop_inv = 1'b0;
    addr_hold = 1'b0; backoff_n = 1'b1; bus_hold = 1'b0;
  endtask

  task automatic ack();
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
  endtask

  function automatic logic [LW-1:0] mk_line(input int tag, input int idx);
    return {23'(tag), 4'(idx)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_hold = 0; backoff_n = 1; bus_hold = 0;
    snoop_n = 1; snoop_inv = 0; snoop_line = '0; wb_ack = 0;
    pl_valid = 0; pl_sel = 0; pl_line = '0; pl_state = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 hit_n", {31'b0, hit_n}, 1);
    check("R1 hitm_n", {31'b0, hitm_n}, 1);
    check("R1 wb_req", {31'b0, wb_req}, 0);
    check("R1 pl_reject", {31'b0, pl_reject}, 0);
    for (int i = 0; i < 16; i++) begin
      snoop(mk_line(0, i), 1'b0, 1);
      check("R1 all lines invalid", {31'b0, hit_n}, 1);
    end

    // R2: strobe without release ignored, strobe high with release ignored
    preload(SEL_D(), mk_line(7, 2), 2'd3, 1'b0, "R10 legal preload");
    snoop(mk_line(7, 2), 1'b1, 0);
    check("R2 no release hit_n", {31'b0, hit_n}, 1);
    check("R2 no release wb_req", {31'b0, wb_req}, 0);
    addr_hold = 1'b1; snoop_line = mk_line(7, 2); snoop_inv = 1'b1;
    @(negedge clk);
    addr_hold = 1'b0; snoop_inv = 1'b0;
    check("R2 strobe idle hit_n", {31'b0, hit_n}, 1);
    snoop(mk_line(7, 2), 1'b0, 2);
    check("R2 line kept hit_n", {31'b0, hit_n}, 0);
    check("R2 line kept hitm_n", {31'b0, hitm_n}, 0);
    ack();

    // R9: same index, other tag misses
    preload(SEL_D(), mk_line(40, 3), 2'd1, 1'b0, "R10 legal preload");
    snoop(mk_line(41, 3), 1'b0, 3);
    check("R9 tag mismatch hit_n", {31'b0, hit_n}, 1);
    snoop(mk_line(40, 4), 1'b0, 3);
    check("R9 index mismatch hit_n", {31'b0, hit_n}, 1);
    snoop(mk_line(40, 3), 1'b0, 3);
    check("R9 tag match hit_n", {31'b0, hit_n}, 0);

    // R6: strobe and preload refused during a pending write-back
    preload(SEL_D(), mk_line(50, 5), 2'd3, 1'b0, "R10 legal preload");
    preload(SEL_L(), mk_line(51, 6), 2'd1, 1'b0, "R10 legal preload");
    snoop(mk_line(50, 5), 1'b0, 1);
    check("R6 pending wb_req", {31'b0, wb_req}, 1);
    snoop(mk_line(51, 6), 1'b1, 1);
    check("R6 wb_line unchanged", {5'b0, wb_line}, {5'b0, mk_line(50, 5)});
    preload(SEL_I(), mk_line(52, 7), 2'd1, 1'b1, "R6 preload refused while busy");
    ack();
    check("R5 ack drops wb_req", {31'b0, wb_req}, 0);
    snoop(mk_line(51, 6), 1'b0, 1);
    check("R6 ignored inquiry left line", {31'b0, hit_n}, 0);
    snoop(mk_line(52, 7), 1'b0, 1);
    check("R6 refused preload not written", {31'b0, hit_n}, 1);

    // R10: refused encodings and forbidden pair
    preload(2'd3, mk_line(60, 8), 2'd1, 1'b1, "R10 select 3 refused");
    preload(SEL_D(), mk_line(61, 9), 2'd2, 1'b0, "R10 legal preload");
    preload(SEL_L(), mk_line(61, 9), 2'd3, 1'b1, "R10 L2 M over data E refused");
    snoop(mk_line(61, 9), 1'b0, 2);
    check("R10 refused M not written hitm_n", {31'b0, hitm_n}, 1);
    check("R10 data E still hits", {31'b0, hit_n}, 0);
    preload(SEL_L(), mk_line(62, 10), 2'd3, 1'b0, "R10 legal preload");
    preload(SEL_D(), mk_line(62, 10), 2'd2, 1'b1, "R10 data E over L2 M refused");
    preload(SEL_D(), mk_line(63, 10), 2'd2, 1'b0, "R10 other tag allowed");

    // Sweep: every legal state mix, both qualifier values
    begin
      int c = 0;
      for (int inv = 0; inv < 2; inv++)
        for (int iv = 0; iv < 2; iv++)
          for (int d = 0; d < 4; d++)
            for (int l = 0; l < 4; l++) begin
              logic [LW-1:0] ln;
              logic any, md;
              if (d == 2 && l == 3) continue;
              ln  = mk_line(100 + c, c);
              any = (iv != 0) || (d != 0) || (l != 0);
              md  = (d == 3) || (l == 3);
              preload(SEL_I(), ln, 2'(iv), 1'b0, "R10 sweep preload");
              preload(SEL_D(), ln, 2'(d), 1'b0, "R10 sweep preload");
              preload(SEL_L(), ln, 2'(l), 1'b0, "R10 sweep preload");
              snoop(ln, inv[0], 1 + (c % 3));
              check("R3 sweep hit_n", {31'b0, hit_n}, {31'b0, ~any});
              check("R4 sweep hitm_n", {31'b0, hitm_n}, {31'b0, ~md});
              check("R5 sweep wb_req", {31'b0, wb_req}, {31'b0, md});
              if (md) begin
                check("R5 sweep wb_line", {5'b0, wb_line}, {5'b0, ln});
                @(negedge clk);
                check("R5 holds without ack", {31'b0, wb_req}, 1);
                ack();
                check("R5 released wb_req", {31'b0, wb_req}, 0);
                check("R5 released hitm_n", {31'b0, hitm_n}, 1);
                check("R3 hit_n held after ack", {31'b0, hit_n}, 0);
                @(negedge clk);
                check("R5 single request", {31'b0, wb_req}, 0);
              end
              snoop(ln, 1'b0, 3);
              if (inv != 0)
                check("R7 all copies invalid", {31'b0, hit_n}, 1);
              else
                check("R8 copies shared", {31'b0, hit_n}, {31'b0, ~any});
              check("R8 no modified left", {31'b0, hitm_n}, 1);
              check("R8 no second request", {31'b0, wb_req}, 0);
              c++;
            end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  function automatic logic [1:0] SEL_I(); return 2'd0; endfunction
  function automatic logic [1:0] SEL_D(); return 2'd1; endfunction
  function automatic logic [1:0] SEL_L(); return 2'd2; endfunction

endmodule